// File: doc/BRIEF.md
# Width-Aware I/O Port Dispatcher

This block sits between a processor's I/O-space request bus and a set of peripherals. Each request carries a 16-bit port address, a size code (byte, word or doubleword), a read/write flag and 32-bit write data. The block looks the port up in a claim table for that access width and, on a hit, fires a one-cycle select strobe to the owning device and returns that device's read data, trimmed to the access width.

Claims are written at run time through a configuration port. One configuration write records a start port, a length, a width and a device number into one of a fixed number of slots. It claims every width-th port from the start port onward, up to the length. Accesses that no slot claims get fallback behaviour. Byte and doubleword reads return all ones and writes vanish. An unclaimed word access is broken into two byte accesses at the port and the port above it, each looked up in the byte table.

Top module: `io_port_dispatch`

## Requirements
- R1: After reset, busy, done, cfg_err and dev_sel are all low and every slot is empty, so every access is unclaimed.
- R2: Only the low 12 bits of req_addr select the table entry, so port 0x1071 reaches the claim on port 0x071; dev_addr still carries the full 16-bit address.
- R3: The byte, word and doubleword tables are independent: a claim made for one width is not seen by an access of another width.
- R4: A slot with start s, length L and size code k claims ports s, s+2^k, s+2·2^k … below s+L. Ports in between are not claimed. When slots overlap, the slot with the higher index wins.
- R5: Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. A request with code 3 completes with err high, rdata zero and no strobe. A configuration write with code 3 raises cfg_err in the next cycle and leaves the slot unchanged.
- R6: A claimed access drives a single one-cycle dev_sel strobe on the owning device's bit. It carries the request's address, size, direction and full write data. Read data comes from that device's 32-bit lane of dev_rdata (lane d at bits 32d+31:32d), masked to 8, 16 or 32 bits.
- R7: An unclaimed byte read returns 0x000000FF and an unclaimed doubleword read returns 0xFFFFFFFF. An unclaimed byte or doubleword write produces no strobe. Every write completes with rdata zero.
- R8: An unclaimed word read at port p becomes two byte reads. The byte from p lands in bits 7:0 and the byte from p+1 in bits 15:8. Each half that the byte table does not claim reads as 0xFF.
- R9: An unclaimed word write at port p becomes a byte write of wdata bits 7:0 to p, then, one cycle later, a byte write of bits 15:8 to p+1.
- R10: A request is taken when req_valid is high and busy is low. busy is high from the next cycle until done. done is a one-cycle pulse two cycles after acceptance for a single access, or three cycles after for a split word, and rdata is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 16 | Port address |
| req_size | input | 2 | Size code (0 byte, 1 word, 2 doubleword, 3 invalid) |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Access in progress; requests are not taken |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion with an invalid size code |
| rdata | output | 32 | Read data, valid with done |
| cfg_valid | input | 1 | Configuration write |
| cfg_slot | input | 3 | Slot index to write |
| cfg_start | input | 12 | First claimed port |
| cfg_len | input | 13 | Range length in ports |
| cfg_size | input | 2 | Width the claim applies to |
| cfg_dev | input | 2 | Owning device number |
| cfg_err | output | 1 | Previous configuration write had an invalid size code |
| dev_sel | output | 4 | One-hot device select strobe |
| dev_addr | output | 16 | Address presented to the device |
| dev_size | output | 2 | Size code presented to the device |
| dev_wr | output | 1 | Direction presented to the device |
| dev_wdata | output | 32 | Write data presented to the device |
| dev_rdata | input | 128 | Read data lanes, one 32-bit lane per device |

## Verification
The assertions take for granted that req_valid is only raised while busy is low, or that a request raised during busy is simply held until it is taken. They also take for granted that devices answer combinationally in the strobe cycle. The bench holds each request for exactly the acceptance edge and waits for busy to drop before the next one. It writes the table only while no access is in flight, so a lookup never sees a claim change halfway through a split word. The bench device model derives each lane's data from dev_addr within the same cycle.

// File: rtl/io_port_dispatch.sv
module io_port_dispatch #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int PORT_BITS = 12,
  parameter int NDEV      = 4,
  parameter int NSLOT     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [1:0]               req_size,
  input  logic                     req_wr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     busy,
  output logic                     done,
  output logic                     err,
  output logic [DATA_W-1:0]        rdata,
  input  logic                     cfg_valid,
  input  logic [$clog2(NSLOT)-1:0] cfg_slot,
  input  logic [PORT_BITS-1:0]     cfg_start,
  input  logic [PORT_BITS:0]       cfg_len,
  input  logic [1:0]               cfg_size,
  input  logic [$clog2(NDEV)-1:0]  cfg_dev,
  output logic                     cfg_err,
  output logic [NDEV-1:0]          dev_sel,
  output logic [ADDR_W-1:0]        dev_addr,
  output logic [1:0]               dev_size,
  output logic                     dev_wr,
  output logic [DATA_W-1:0]        dev_wdata,
  input  logic [NDEV*DATA_W-1:0]   dev_rdata
);
  localparam int DEV_W  = $clog2(NDEV);
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int LEN_W  = PORT_BITS + 1;
  localparam logic [1:0] SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_BAD = 2'd3;
  localparam logic [DATA_W-1:0] ONES  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] BYTE1 = {{(DATA_W-8){1'b0}}, 8'hFF};
  localparam logic [DATA_W-1:0] WORD1 = {{(DATA_W-16){1'b0}}, 16'hFFFF};

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_FIN} state_t;
  state_t state;

  logic [PORT_BITS-1:0] s_start [NSLOT];
  logic [LEN_W-1:0]     s_len   [NSLOT];
  logic [1:0]           s_size  [NSLOT];
  logic [DEV_W-1:0]     s_dev   [NSLOT];

  logic [ADDR_W-1:0] c_addr;
  logic [1:0]        c_size;
  logic              c_wr;
  logic [DATA_W-1:0] c_wdata;
  logic [DATA_W-1:0] rd_q;
  logic              err_q, cfg_err_q;

  wire [ADDR_W-1:0]    a_hi = c_addr + ADDR_W'(1);
  wire                 in_hi = (state == S_HI);
  wire [PORT_BITS-1:0] idx = in_hi ? a_hi[PORT_BITS-1:0] : c_addr[PORT_BITS-1:0];
  wire                 bad = (c_size == SZ_BAD);

  logic [NSLOT-1:0] hit_w, hit_b;
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    wire [LEN_W-1:0] off = {1'b0, idx} - {1'b0, s_start[i]};
    wire [1:0] amask = (s_size[i] == SZ_BYTE) ? 2'b00 :
                       (s_size[i] == SZ_WORD) ? 2'b01 : 2'b11;
    wire in_rng = (idx >= s_start[i]) && (off < s_len[i]);
    assign hit_w[i] = in_rng && (s_size[i] == c_size) && ((off[1:0] & amask) == 2'b00);
    assign hit_b[i] = in_rng && (s_size[i] == SZ_BYTE);
  end

  logic             w_hit, b_hit;
  logic [DEV_W-1:0] w_dev, b_dev;
  always_comb begin
    w_hit = 1'b0; w_dev = '0; b_hit = 1'b0; b_dev = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (hit_w[i]) begin w_hit = 1'b1; w_dev = s_dev[i]; end
      if (hit_b[i]) begin b_hit = 1'b1; b_dev = s_dev[i]; end
    end
  end

  wire direct = (state == S_LO) && !bad && w_hit;
  wire half   = ((state == S_LO) && !bad && !w_hit && c_size == SZ_WORD) || in_hi;
  wire [DEV_W-1:0]  cur_dev = direct ? w_dev : b_dev;
  wire [DATA_W-1:0] lane = dev_rdata[cur_dev*DATA_W +: DATA_W];
  wire [7:0]        half_byte = b_hit ? lane[7:0] : 8'hFF;

  always_comb begin
    dev_sel = '0;
    if (direct || (half && b_hit)) dev_sel = NDEV'(1) << cur_dev;
  end

  assign dev_addr  = in_hi ? a_hi : c_addr;
  assign dev_size  = half ? SZ_BYTE : c_size;
  assign dev_wr    = c_wr;
  assign dev_wdata = !half ? c_wdata :
                     in_hi ? {{(DATA_W-8){1'b0}}, c_wdata[15:8]} :
                             {{(DATA_W-8){1'b0}}, c_wdata[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      c_addr <= '0; c_size <= '0; c_wr <= 1'b0; c_wdata <= '0;
      rd_q <= '0; err_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          c_addr <= req_addr; c_size <= req_size; c_wr <= req_wr; c_wdata <= req_wdata;
          err_q <= 1'b0;
          state <= S_LO;
        end
        S_LO: begin
          state <= S_FIN;
          if (bad) begin
            err_q <= 1'b1; rd_q <= '0;
          end else if (w_hit) begin
            rd_q <= c_wr ? '0 :
                    lane & ((c_size == SZ_BYTE) ? BYTE1 : (c_size == SZ_WORD) ? WORD1 : ONES);
          end else if (c_size == SZ_WORD) begin
            rd_q <= c_wr ? '0 : {{(DATA_W-8){1'b0}}, half_byte};
            state <= S_HI;
          end else begin
            rd_q <= c_wr ? '0 : ((c_size == SZ_BYTE) ? BYTE1 : ONES);
          end
        end
        S_HI: begin
          if (!c_wr) rd_q[15:8] <= half_byte;
          state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_err_q <= 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
        s_start[i] <= '0; s_len[i] <= '0; s_size[i] <= '0; s_dev[i] <= '0;
      end
    end else begin
      cfg_err_q <= cfg_valid && (cfg_size == SZ_BAD);
      if (cfg_valid && cfg_size != SZ_BAD) begin
        s_start[cfg_slot] <= cfg_start;
        s_len[cfg_slot]   <= cfg_len;
        s_size[cfg_slot]  <= cfg_size;
        s_dev[cfg_slot]   <= cfg_dev;
      end
    end
  end

  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FIN);
  assign err     = done && err_q;
  assign rdata   = rd_q;
  assign cfg_err = cfg_err_q;
endmodule

// File: rtl/io_port_dispatch_chk.sv
module io_port_dispatch_chk #(
  parameter int NDEV = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_size,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            cfg_valid,
  input logic [1:0]      cfg_size,
  input logic            cfg_err,
  input logic [NDEV-1:0] dev_sel
);
  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dev_sel));
  // R10
  sel_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (|dev_sel) |-> busy);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !busy) |=> busy);
  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(done));
  // R5
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_size == 2'd3) |=> (dev_sel == '0) ##1 (done && err));
  // R5
  cfg_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_size == 2'd3) |=> cfg_err);
  // R5
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && cfg_size == 2'd3) |=> !cfg_err);
endmodule

bind io_port_dispatch io_port_dispatch_chk #(.NDEV(NDEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
  .busy(busy), .done(done), .err(err), .cfg_valid(cfg_valid),
  .cfg_size(cfg_size), .cfg_err(cfg_err), .dev_sel(dev_sel)
);

// File: tb/io_port_dispatch_tb.sv
module io_port_dispatch_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_wr = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, err;
  logic [31:0] rdata;
  logic        cfg_valid = 1'b0;
  logic [2:0]  cfg_slot = '0;
  logic [11:0] cfg_start = '0;
  logic [12:0] cfg_len = '0;
  logic [1:0]  cfg_size = '0;
  logic [1:0]  cfg_dev = '0;
  logic        cfg_err;
  logic [3:0]  dev_sel;
  logic [15:0] dev_addr;
  logic [1:0]  dev_size;
  logic        dev_wr;
  logic [31:0] dev_wdata;
  logic [127:0] dev_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_port_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_wr(req_wr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .cfg_valid(cfg_valid), .cfg_slot(cfg_slot), .cfg_start(cfg_start),
    .cfg_len(cfg_len), .cfg_size(cfg_size), .cfg_dev(cfg_dev), .cfg_err(cfg_err),
    .dev_sel(dev_sel), .dev_addr(dev_addr), .dev_size(dev_size), .dev_wr(dev_wr),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  // device model: lane d = {d+1, 0xC3, dev_addr}
  always_comb
    for (int d = 0; d < 4; d++) dev_rdata[d*32 +: 32] = {8'(d + 1), 8'hC3, dev_addr};

  typedef struct {
    logic [31:0] rdata;
    logic        err;
    int          nstb;
    logic [3:0]  sel0, sel1;
    logic [15:0] a0, a1;
    logic [31:0] w0, w1;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  function automatic exp_t mk(logic [31:0] rd, logic e, int n,
                              logic [3:0] s0, logic [15:0] a0, logic [31:0] w0,
                              logic [3:0] s1, logic [15:0] a1, logic [31:0] w1);
    exp_t x;
    x.rdata = rd; x.err = e; x.nstb = n;
    x.sel0 = s0; x.a0 = a0; x.w0 = w0; x.sel1 = s1; x.a1 = a1; x.w1 = w1;
    return x;
  endfunction

  // monitor / scoreboard
  int          nstb = 0;
  logic [3:0]  st_sel [2];
  logic [15:0] st_addr [2];
  logic [31:0] st_wd [2];

  always @(negedge clk) begin
    if (rst_n) begin
      if (dev_sel != '0) begin
        if (nstb < 2) begin
          st_sel[nstb] = dev_sel; st_addr[nstb] = dev_addr; st_wd[nstb] = dev_wdata;
        end
        nstb++;
      end
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rdata == e.rdata, t, "rdata", rdata, e.rdata);
          chk(err == e.err, t, "err", 32'(err), 32'(e.err));
          chk(nstb == e.nstb, t, "strobe count", nstb, e.nstb);
          if (nstb == e.nstb && nstb >= 1) begin
            chk(st_sel[0] == e.sel0, t, "sel0", 32'(st_sel[0]), 32'(e.sel0));
            chk(st_addr[0] == e.a0, t, "addr0", 32'(st_addr[0]), 32'(e.a0));
            chk(st_wd[0] == e.w0, t, "wdata0", st_wd[0], e.w0);
          end
          if (nstb == e.nstb && nstb == 2) begin
            chk(st_sel[1] == e.sel1, t, "sel1", 32'(st_sel[1]), 32'(e.sel1));
            chk(st_addr[1] == e.a1, t, "addr1", 32'(st_addr[1]), 32'(e.a1));
            chk(st_wd[1] == e.w1, t, "wdata1", st_wd[1], e.w1);
          end
        end
        nstb = 0;
      end
    end
  end

  task automatic access(input logic [15:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] wd, input exp_t e, input string tag,
                        input int cyc);
    int n;
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_addr = a; req_size = sz; req_wr = wr; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10", "busy after accept", 32'(busy), 32'd1);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    chk(n == cyc, "R10", "busy cycles", n, cyc);
  endtask

  task automatic cfg(input logic [2:0] slot, input logic [11:0] st, input logic [12:0] len,
                     input logic [1:0] sz, input logic [1:0] dv, input logic e, input string tag);
    @(negedge clk);
    cfg_slot = slot; cfg_start = st; cfg_len = len; cfg_size = sz; cfg_dev = dv;
    cfg_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
    chk(cfg_err == e, tag, "cfg_err", 32'(cfg_err), 32'(e));
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy", 32'(busy), 0);
    chk(done == 0, "R1", "done", 32'(done), 0);
    chk(cfg_err == 0, "R1", "cfg_err", 32'(cfg_err), 0);
    chk(dev_sel == 0, "R1", "dev_sel", 32'(dev_sel), 0);
    // R1 empty table
    access(16'h0070, 2'd0, 0, 0, mk(32'hFF, 0, 0, 0, 0, 0, 0, 0, 0), "R1", 2);
    access(16'h01F0, 2'd2, 0, 0, mk(32'hFFFFFFFF, 0, 0, 0, 0, 0, 0, 0, 0), "R1", 2);

    cfg(3'd0, 12'h070, 13'd2, 2'd0, 2'd1, 0, "R4");
    cfg(3'd1, 12'h1F0, 13'd4, 2'd2, 2'd2, 0, "R4");
    cfg(3'd2, 12'h1F0, 13'd2, 2'd1, 2'd3, 0, "R3");
    cfg(3'd3, 12'h100, 13'd8, 2'd1, 2'd0, 0, "R4");
    cfg(3'd4, 12'h102, 13'd2, 2'd1, 2'd2, 0, "R4");
    // R5 invalid cfg size must leave slot 3 intact
    cfg(3'd3, 12'h300, 13'd8, 2'd3, 2'd1, 1, "R5");

    // R6 claimed byte read
    access(16'h0070, 2'd0, 0, 0, mk(32'h70, 0, 1, 4'b0010, 16'h0070, 0, 0, 0, 0), "R6", 2);
    // R2 upper address bits ignored by lookup
    access(16'h1071, 2'd0, 0, 0, mk(32'h71, 0, 1, 4'b0010, 16'h1071, 0, 0, 0, 0), "R2", 2);
    // R7 unclaimed byte read
    access(16'h0072, 2'd0, 0, 0, mk(32'hFF, 0, 0, 0, 0, 0, 0, 0, 0), "R7", 2);
    // R6 claimed dword read
    access(16'h01F0, 2'd2, 0, 0, mk(32'h03C301F0, 0, 1, 4'b0100, 16'h01F0, 0, 0, 0, 0), "R6", 2);
    // R3 byte table does not see word/dword claims
    access(16'h01F0, 2'd0, 0, 0, mk(32'hFF, 0, 0, 0, 0, 0, 0, 0, 0), "R3", 2);
    // R3 word table has its own claim at the same port
    access(16'h01F0, 2'd1, 0, 0, mk(32'h01F0, 0, 1, 4'b1000, 16'h01F0, 0, 0, 0, 0), "R3", 2);
    // R4 stepping: dword claim length 4 covers only 0x1F0
    access(16'h01F4, 2'd2, 0, 0, mk(32'hFFFFFFFF, 0, 0, 0, 0, 0, 0, 0, 0), "R4", 2);
    // R4 (and R5: slot 3 kept) word at 0x104
    access(16'h0104, 2'd1, 0, 0, mk(32'h0104, 0, 1, 4'b0001, 16'h0104, 0, 0, 0, 0), "R4", 2);
    // R4 odd port not claimed -> R8 split, both halves unclaimed
    access(16'h0103, 2'd1, 0, 0, mk(32'hFFFF, 0, 0, 0, 0, 0, 0, 0, 0), "R8", 3);
    // R4 higher slot wins on overlap
    access(16'h0102, 2'd1, 0, 0, mk(32'h0102, 0, 1, 4'b0100, 16'h0102, 0, 0, 0, 0), "R4", 2);
    // R8 split word read, both halves claimed
    access(16'h0070, 2'd1, 0, 0,
           mk(32'h7170, 0, 2, 4'b0010, 16'h0070, 0, 4'b0010, 16'h0071, 0), "R8", 3);
    // R8 split word read, only high half claimed
    access(16'h006F, 2'd1, 0, 0, mk(32'h70FF, 0, 1, 4'b0010, 16'h0070, 0, 0, 0, 0), "R8", 3);
    // R9 split word write order
    access(16'h0070, 2'd1, 1, 32'h0000BEEF,
           mk(32'h0, 0, 2, 4'b0010, 16'h0070, 32'hEF, 4'b0010, 16'h0071, 32'hBE), "R9", 3);
    // R7 unclaimed writes discarded
    access(16'h0072, 2'd0, 1, 32'h55, mk(32'h0, 0, 0, 0, 0, 0, 0, 0, 0), "R7", 2);
    access(16'h0200, 2'd2, 1, 32'hCAFEF00D, mk(32'h0, 0, 0, 0, 0, 0, 0, 0, 0), "R7", 2);
    // R5 invalid request size
    access(16'h0070, 2'd3, 0, 0, mk(32'h0, 1, 0, 0, 0, 0, 0, 0, 0), "R5", 2);
    // R6 claimed byte write carries full data
    access(16'h0071, 2'd0, 1, 32'h12, mk(32'h0, 0, 1, 4'b0010, 16'h0071, 32'h12, 0, 0, 0), "R6", 2);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "pending completions", exp_q.size(), 0);
    summary();
  end
endmodule